// File: doc/BRIEF.md
# Error-Correcting Word Memory with Test Fill

This block wraps a 256-word, 32-bit on-chip memory with single-error-correct, double-error-detect coding. Every word is stored together with its check bits. A read returns the word corrected when one bit has flipped and flags it as uncorrectable when two bits have flipped. Checking is switched by a plain enable input that system logic holds low out of reset. Software can therefore first run a test fill that writes one chosen pattern into every location. Only then does it turn checking on, so that words never written cannot raise false alarms. Two saturating counters record correctable and uncorrectable events, and a clear strobe empties both.

Functional access uses a valid/ready request channel and a valid/ready response channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A read request produces one response on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `req_ready` stays low, so back-pressure on the response side stalls new requests. Writes produce no response. A test-only injection port flips chosen bits of one stored codeword, so that error handling can be exercised.

Top module: `secded_ram`

## Requirements
- R1: After reset `rsp_valid`, `fill_busy`, `ce_pulse` and `ue_pulse` are 0, both counters are 0, and `req_ready` is 1.
- R2: A read taken at an edge raises `rsp_valid` after that edge. While `rsp_valid` is 1 and `rsp_ready` is 0, the response data stays stable and `req_ready` is 0. The response is dropped at the first edge where `rsp_ready` is 1.
- R3: A word that is written and then read back with checking enabled returns the written data with no error pulse. The stored codeword is 39 bits wide. Bit 0 holds the overall even parity. Bits 1, 2, 4, 8, 16 and 32 hold the Hamming checks. Data bits 0 to 31 sit in ascending order at the remaining indices 3, 5, 6, 7, 9 … 38.
- R4: With `edac_en` at 0, a read returns the stored data bits unchanged, raises no pulse and leaves both counters unchanged.
- R5: With checking enabled, a word with one flipped codeword bit is returned corrected. `ce_pulse` is 1 in the response's first cycle only.
- R6: With checking enabled, a word with two flipped codeword bits raises `ue_pulse` for one cycle, and the returned data keeps the flipped data bits. `ce_pulse` and `ue_pulse` are never 1 together.
- R7: Each correctable or uncorrectable event adds one to its own counter. A counter at its all-ones value stays there.
- R8: `cnt_clr` zeroes both counters at the next edge, and it wins over an increment in the same cycle.
- R9: A `fill_start` pulse seen while idle writes the `fill_data` sampled at that edge into every one of the 256 words. `fill_busy` is 1 for exactly 256 cycles, and during that time `req_ready` is 0 and `fill_start` is ignored.
- R10: `inj_valid` XORs `inj_mask` into the stored codeword at `inj_addr`. The injection is dropped when a fill or a functional write is active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edac_en | input | 1 | Enables correction, flags and counting on reads |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 32 | Read data |
| fill_start | input | 1 | Starts a test fill of the whole array |
| fill_data | input | 32 | Pattern for the test fill |
| fill_busy | output | 1 | Test fill in progress |
| inj_valid | input | 1 | Test-only bit-flip request |
| inj_addr | input | 8 | Word to corrupt |
| inj_mask | input | 39 | Codeword bits to flip |
| ce_pulse | output | 1 | Correctable error seen on the current response |
| ue_pulse | output | 1 | Uncorrectable error seen on the current response |
| cnt_clr | input | 1 | Clears both error counters |
| ce_count | output | 8 | Correctable error count, saturating |
| ue_count | output | 8 | Uncorrectable error count, saturating |

## Verification
On every cycle the assertions check that a stalled response holds steady, that error pulses come only with a fresh response and never both at once, that pulses stay quiet with checking disabled, that counters saturate and clear as required, and that a fill ends on the last address. Only the bench scenarios can show the values themselves: that the corrected data equals what was written, that a double error leaves the data bits flipped, that a dropped injection or a fill really left the array clean, and that a counter reaches exactly its all-ones value after a long run of errors.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int unsigned hamming_bits(int unsigned dw);
    int unsigned p;
    p = 1;
    while ((32'd1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc #(
  parameter int DW = 32,
  localparam int P  = secded_pkg::hamming_bits(DW),
  localparam int N  = DW + P,
  localparam int CW = N + 1
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code
);
  always_comb begin
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    // place data bits at the non-power-of-two positions
    for (int j = 1; j <= N; j++) begin
      if (!secded_pkg::is_pow2(j)) begin
        c[j] = data[k];
        k = k + 1;
      end
    end
    // each check bit covers the positions whose index has its bit set
    for (int i = 0; i < P; i++) begin
      for (int j = 1; j <= N; j++) begin
        if (!secded_pkg::is_pow2(j) && j[i]) c[1 << i] = c[1 << i] ^ c[j];
      end
    end
    c[0] = ^c[N:1];
    code = c;
  end
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec #(
  parameter int DW = 32,
  localparam int P  = secded_pkg::hamming_bits(DW),
  localparam int N  = DW + P,
  localparam int CW = N + 1
) (
  input  logic [CW-1:0] code,
  input  logic          en,
  output logic [DW-1:0] data,
  output logic          ce,
  output logic          ue
);
  logic [P-1:0]  syn;
  logic          odd;
  logic [CW-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int j = 1; j <= N; j++) begin
      if (code[j]) syn = syn ^ j[P-1:0];
    end
    odd = ^code;
  end

  always_comb begin
    fixed = code;
    ce    = 1'b0;
    ue    = 1'b0;
    if (en) begin
      if (odd) begin
        if (int'(syn) <= N) begin
          ce = 1'b1;
          if (syn != '0) fixed[syn] = ~code[syn];
        end else begin
          ue = 1'b1;
        end
      end else if (syn != '0) begin
        ue = 1'b1;
      end
    end
  end

  always_comb begin
    int k;
    k = 0;
    data = '0;
    for (int j = 1; j <= N; j++) begin
      if (!secded_pkg::is_pow2(j)) begin
        data[k] = fixed[j];
        k = k + 1;
      end
    end
  end

  always_comb begin
    a_excl_r6: assert (!(ce && ue));
  end
endmodule

// File: rtl/secded_cnt.sv
`timescale 1ns/1ps
module secded_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  p_hold_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/secded_fill.sv
`timescale 1ns/1ps
module secded_fill #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        addr <= '0;
      end
    end else if (addr == LAST) begin
      busy <= 1'b0;
    end else begin
      addr <= addr + 1'b1;
    end
  end

  p_fill_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(addr) == LAST);
  p_fill_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr == '0);
endmodule

// File: rtl/secded_ram.sv
`timescale 1ns/1ps
module secded_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = DW + secded_pkg::hamming_bits(DW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edac_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             fill_start,
  input  logic [DW-1:0]    fill_data,
  output logic             fill_busy,
  input  logic             inj_valid,
  input  logic [AW-1:0]    inj_addr,
  input  logic [CW-1:0]    inj_mask,
  output logic             ce_pulse,
  output logic             ue_pulse,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] ce_count,
  output logic [CNT_W-1:0] ue_count
);
  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_code, fill_code_d, fill_code_q;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] dec_data;
  logic          dec_ce, dec_ue;
  logic          take, rd_acc, wr_acc;
  logic [1:0]    ev_inc;
  logic [CNT_W-1:0] counts [2];

  assign req_ready = !fill_busy && (!rsp_valid || rsp_ready);
  assign take      = req_valid && req_ready;
  assign rd_acc    = take && !req_write;
  assign wr_acc    = take && req_write;

  secded_enc #(.DW(DW)) u_enc_wr   (.data(req_wdata), .code(wr_code));
  secded_enc #(.DW(DW)) u_enc_fill (.data(fill_data), .code(fill_code_d));

  secded_fill #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_start),
    .busy(fill_busy), .addr(fill_addr));

  always_ff @(posedge clk) begin
    if (fill_start && !fill_busy) fill_code_q <= fill_code_d;
  end

  // single write port: fill, then functional write, then injection
  always_ff @(posedge clk) begin
    if (fill_busy)      mem[fill_addr] <= fill_code_q;
    else if (wr_acc)    mem[req_addr]  <= wr_code;
    else if (inj_valid) mem[inj_addr]  <= mem[inj_addr] ^ inj_mask;
  end

  secded_dec #(.DW(DW)) u_dec (
    .code(mem[req_addr]), .en(edac_en),
    .data(dec_data), .ce(dec_ce), .ue(dec_ue));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ce_pulse  <= 1'b0;
      ue_pulse  <= 1'b0;
    end else begin
      ce_pulse <= rd_acc && dec_ce;
      ue_pulse <= rd_acc && dec_ue;
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= dec_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign ev_inc = {rd_acc && dec_ue, rd_acc && dec_ce};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    secded_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[g]), .clr(cnt_clr),
      .cnt(counts[g]));
  end
  assign ce_count = counts[0];
  assign ue_count = counts[1];

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !edac_en) |=> (!ce_pulse && !ue_pulse));
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> (!ce_pulse && !ue_pulse));
  p_pulse_has_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pulse || ue_pulse) |-> rsp_valid);
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_pulse && ue_pulse));
  p_no_take_in_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !take);
endmodule

// File: tb/secded_ram_test.sv
`timescale 1ns/1ps
module secded_ram_test;
  localparam int PERIOD = 10;
  localparam int CWB = 39;

  logic clk = 0, rst_n = 0, edac_en = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [7:0] req_addr = 0, inj_addr = 0;
  logic [31:0] req_wdata = 0, fill_data = 0;
  logic fill_start = 0, inj_valid = 0, cnt_clr = 0;
  logic [CWB-1:0] inj_mask = 0;
  logic req_ready, rsp_valid, fill_busy, ce_pulse, ue_pulse;
  logic [31:0] rsp_rdata;
  logic [7:0] ce_count, ue_count;

  int total = 0, fails = 0;
  int ce_exp = 0, ue_exp = 0;

  always #(PERIOD/2) clk = ~clk;

  secded_ram uut (
    .clk(clk), .rst_n(rst_n), .edac_en(edac_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .fill_start(fill_start), .fill_data(fill_data), .fill_busy(fill_busy),
    .inj_valid(inj_valid), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .cnt_clr(cnt_clr),
    .ce_count(ce_count), .ue_count(ue_count));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // codeword index of data bit k: the k-th index from 3 upward that is not a power of two
  function automatic logic [CWB-1:0] dmask(input int k);
    int n = 0;
    for (int j = 1; j < CWB; j++) begin
      if ((j & (j - 1)) != 0) begin
        if (n == k) return CWB'(1) << j;
        n++;
      end
    end
    return '0;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_inject(input logic [7:0] a, input logic [CWB-1:0] m);
    @(negedge clk);
    inj_valid = 1; inj_addr = a; inj_mask = m;
    @(posedge clk); #1;
    inj_valid = 0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d,
                         output logic ce, output logic ue, output logic after);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
    d = rsp_rdata; ce = ce_pulse; ue = ue_pulse;
    @(posedge clk); #1;
    after = ce_pulse | ue_pulse;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0 && fill_busy == 0, "R1", "valid/busy", {rsp_valid, fill_busy}, 0);
    chk(ce_pulse == 0 && ue_pulse == 0, "R1", "pulses", {ce_pulse, ue_pulse}, 0);
    chk(ce_count == 0 && ue_count == 0, "R1", "counters", {ce_count, ue_count}, 0);
    @(negedge clk); rst_n = 1;
    #1 chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
  endtask

  task automatic t_fill;
    int busy_n = 0;
    logic [31:0] d; logic ce, ue, af;
    @(negedge clk);
    fill_start = 1; fill_data = 32'hA5C3_0F96;
    @(posedge clk); #1;
    fill_start = 0; fill_data = 32'h0;
    chk(req_ready == 0, "R9", "req_ready in fill", req_ready, 0);
    // injection during the fill must be dropped
    inj_valid = 1; inj_addr = 8'd3; inj_mask = dmask(4);
    while (fill_busy && busy_n < 400) begin
      busy_n++;
      if (busy_n == 2) fill_start = 1;
      @(posedge clk); #1;
      inj_valid = 0;
    end
    fill_start = 0;
    chk(busy_n == 256, "R9", "busy cycles", busy_n, 256);
    edac_en = 1;
    do_read(8'd0, d, ce, ue, af);
    chk(d == 32'hA5C3_0F96 && !ce && !ue, "R9", "word 0", d, 32'hA5C3_0F96);
    do_read(8'd255, d, ce, ue, af);
    chk(d == 32'hA5C3_0F96 && !ce && !ue, "R9", "word 255", d, 32'hA5C3_0F96);
    do_read(8'd3, d, ce, ue, af);
    chk(d == 32'hA5C3_0F96 && !ce && !ue, "R10", "inject in fill dropped", d, 32'hA5C3_0F96);
  endtask

  task automatic t_write_read;
    logic [31:0] d; logic ce, ue, af;
    logic [31:0] pat [4] = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001};
    for (int i = 0; i < 4; i++) do_write(8'(20 + i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      do_read(8'(20 + i), d, ce, ue, af);
      chk(d == pat[i] && !ce && !ue, "R3", "readback", d, pat[i]);
    end
    chk(ce_count == 0 && ue_count == 0, "R3", "no events", {ce_count, ue_count}, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] d; logic ce, ue, af;
    do_write(8'd5, 32'hCAFE_0000);
    do_inject(8'd5, dmask(13));
    edac_en = 0;
    do_read(8'd5, d, ce, ue, af);
    chk(d == (32'hCAFE_0000 ^ 32'h2000), "R4", "raw data", d, 32'hCAFE_0000 ^ 32'h2000);
    chk(!ce && !ue && ce_count == 0, "R4", "quiet", {ce, ue, ce_count}, 0);
    edac_en = 1;
  endtask

  task automatic t_single;
    logic [31:0] d; logic ce, ue, af;
    do_read(8'd5, d, ce, ue, af);
    ce_exp++;
    chk(d == 32'hCAFE_0000, "R5", "corrected data", d, 32'hCAFE_0000);
    chk(ce && !ue && !af, "R5", "ce one cycle", {ce, ue, af}, 3'b100);
    chk(ce_count == 8'(ce_exp), "R7", "ce_count", ce_count, ce_exp);
    do_write(8'd6, 32'h0BAD_F00D);
    do_inject(8'd6, CWB'(1));
    do_read(8'd6, d, ce, ue, af);
    ce_exp++;
    chk(d == 32'h0BAD_F00D && ce && !ue, "R5", "parity bit flip", d, 32'h0BAD_F00D);
    do_write(8'd8, 32'h5555_AAAA);
    do_inject(8'd8, CWB'(1) << 16);
    do_read(8'd8, d, ce, ue, af);
    ce_exp++;
    chk(d == 32'h5555_AAAA && ce, "R5", "check bit flip", d, 32'h5555_AAAA);
  endtask

  task automatic t_double;
    logic [31:0] d; logic ce, ue, af;
    do_write(8'd7, 32'h1357_9BDF);
    do_inject(8'd7, dmask(0) | dmask(31));
    do_read(8'd7, d, ce, ue, af);
    ue_exp++;
    chk(d == (32'h1357_9BDF ^ 32'h8000_0001), "R6", "uncorrected data", d, 32'h1357_9BDF ^ 32'h8000_0001);
    chk(ue && !ce && !af, "R6", "ue one cycle", {ue, ce, af}, 3'b100);
    chk(ue_count == 8'(ue_exp) && ce_count == 8'(ce_exp), "R7", "counts", {ue_count, ce_count}, {8'(ue_exp), 8'(ce_exp)});
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'd22;
    @(posedge clk); #1;
    req_valid = 0;
    held = rsp_rdata;
    chk(rsp_valid == 1 && held == 32'h1234_5678, "R2", "response", held, 32'h1234_5678);
    chk(req_ready == 0, "R2", "ready low on stall", req_ready, 0);
    repeat (3) @(posedge clk);
    #1 chk(rsp_valid == 1 && rsp_rdata == held, "R2", "held", rsp_rdata, held);
    rsp_ready = 1;
    @(posedge clk); #1;
    chk(rsp_valid == 0 && req_ready == 1, "R2", "drained", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_write_wins;
    logic [31:0] d; logic ce, ue, af;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'd9; req_wdata = 32'h7777_1111;
    inj_valid = 1; inj_addr = 8'd9; inj_mask = dmask(2);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; inj_valid = 0;
    do_read(8'd9, d, ce, ue, af);
    chk(d == 32'h7777_1111 && !ce && !ue, "R10", "write beats inject", d, 32'h7777_1111);
  endtask

  task automatic t_saturate;
    logic [31:0] d; logic ce, ue, af;
    @(negedge clk); cnt_clr = 1;
    @(posedge clk); #1; cnt_clr = 0;
    chk(ce_count == 0 && ue_count == 0, "R8", "clear", {ce_count, ue_count}, 0);
    for (int i = 0; i < 260; i++) do_read(8'd5, d, ce, ue, af);
    chk(ce_count == 8'hFF, "R7", "saturated", ce_count, 8'hFF);
    // clear and increment in the same cycle
    @(negedge clk);
    cnt_clr = 1; req_valid = 1; req_write = 0; req_addr = 8'd5;
    @(posedge clk); #1;
    cnt_clr = 0; req_valid = 0;
    chk(ce_count == 0 && ce_pulse == 1, "R8", "clear wins", {ce_count, ce_pulse}, 9'h001);
  endtask

  initial begin
    t_reset;
    t_fill;
    t_write_read;
    t_disabled;
    t_single;
    t_double;
    t_backpressure;
    t_write_wins;
    t_saturate;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule